// File: doc/BRIEF.md
# Cache Victim Way Selector with Lockdown

This block picks the way that receives a new line when a set-associative cache fills after a miss. It serves several cache channels at once (by default two: one for instructions, one for data). Each channel has its own round-robin counter and its own lockdown register. A shared control input chooses how the base way is found. In round-robin mode it comes from the channel's counter. Otherwise it comes from a free-running LFSR that all channels share.

The lockdown register sets aside the low-numbered ways. When its load bit is clear, the base way is ORed with the register's way field. That field then acts as the lowest way a fill may use. When the load bit is set, every fill goes to exactly the way named in the field, so locked contents can be loaded. A fill strobe carries the set index of the miss. One cycle later the block presents the chosen way and the line index that the tag and data arrays use.

Top module: `victim_way_select`

## Requirements
- R1: After reset, every `vict_valid` bit is 0, every lockdown register reads 0, and every round-robin counter is 0, so the first round-robin fill of a channel picks way 0.
- R2: With `rr_mode`=1, a fill picks the channel's counter value, and the counter then advances by one, wrapping modulo the way count (0,1,2,3,0,...). The counter advances on every round-robin fill, including load-mode fills.
- R3: The round-robin counter does not change in cycles without a fill, or on fills made while `rr_mode`=0.
- R4: With `rr_mode`=0, the base way is the two low bits of a 16-bit Galois LFSR (right shift, tap mask 0xB400, seed 0xACE1) that advances every cycle. Over 64 fills with the lockdown register at 0, all four ways occur.
- R5: With the load bit (lockdown bit 31) clear, the chosen way is the base way ORed with lockdown bits [1:0].
- R6: With the load bit set, the chosen way equals lockdown bits [1:0], whatever the counter or LFSR holds.
- R7: `vict_line` of a channel is {set index, way}: the set index is shifted left by log2 of the way count, and the way sits in bits [1:0].
- R8: `vict_valid` of a channel is 1 exactly in the cycle after a cycle with its `fill_req`. `vict_way` and `vict_line` are meaningful in that cycle only. A fill uses the lockdown value held before any write in the same cycle.
- R9: A write strobe on `lock_we[c]` stores all 32 bits of `lock_wdata` into channel c's lockdown register, and they read back unchanged on `lock_rdata` from the next cycle.
- R10: Channels are independent: a fill or lockdown write on one channel leaves the other channel's counter, lockdown value and outputs unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 1 = round-robin base, 0 = LFSR base (shared by all channels) |
| fill_req | input | NCH | Fill strobe per channel |
| fill_set | input | NCH*SET_W | Set index per channel |
| lock_we | input | NCH | Lockdown register write strobe per channel |
| lock_wdata | input | LOCK_W | Lockdown write data, shared |
| lock_rdata | output | NCH*LOCK_W | Lockdown register contents per channel |
| vict_valid | output | NCH | Registered fill result valid |
| vict_way | output | NCH*WAY_W | Chosen way per channel |
| vict_line | output | NCH*LINE_W | Line index {set, way} per channel |

## Verification
The bench builds the block with its defaults: two channels, four ways, 32 sets and a 32-bit lockdown register with the load bit at position 31. Two channels are enough to show that counters and lockdown values stay separate even when both channels fill in the same cycle. Four ways let the minimum-way OR produce both restricted ranges ({2,3} and {3}) and show the wrap of the counter. The 5-bit set index places the way in bits [1:0] of a 7-bit line index, which is easy to check.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
   typedef enum logic {
      BASE_RANDOM = 1'b0,
      BASE_ROUND  = 1'b1
   } base_src_e;

   function automatic logic [15:0] lfsr_step16(input logic [15:0] s, input logic [15:0] taps);
      return s[0] ? ({1'b0, s[15:1]} ^ taps) : {1'b0, s[15:1]};
   endfunction
endpackage

// File: rtl/vsel_lfsr.sv
module vsel_lfsr #(
   parameter int          W    = 16,
   parameter logic [W-1:0] TAPS = 16'hB400,
   parameter logic [W-1:0] SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   initial begin
      if (SEED == '0) $error("vsel_lfsr: seed must be nonzero");
      if (W < 2)      $error("vsel_lfsr: width too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEED;
      else        state <= state[0] ? ({1'b0, state[W-1:1]} ^ TAPS) : {1'b0, state[W-1:1]};
   end
endmodule

// File: rtl/vsel_rr_count.sv
module vsel_rr_count #(
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [WAY_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/vsel_lane.sv
module vsel_lane
   import vsel_pkg::*;
#(
   parameter int WAY_W    = 2,
   parameter int SET_W    = 5,
   parameter int LOCK_W   = 32,
   parameter int LOAD_BIT = 31,
   localparam int LINE_W  = SET_W + WAY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rr_mode,
   input  logic [WAY_W-1:0]  rnd_way,
   input  logic              fill_req,
   input  logic [SET_W-1:0]  fill_set,
   input  logic              lock_we,
   input  logic [LOCK_W-1:0] lock_wdata,
   output logic [LOCK_W-1:0] lock_q,
   output logic              vld,
   output logic [WAY_W-1:0]  way,
   output logic [LINE_W-1:0] line
);
   base_src_e        src;
   logic [WAY_W-1:0] rr_cnt;
   logic [WAY_W-1:0] base_way;
   logic [WAY_W-1:0] min_way;
   logic [WAY_W-1:0] pick;
   logic             load_mode;

   assign src = rr_mode ? BASE_ROUND : BASE_RANDOM;

   vsel_rr_count #(.WAY_W(WAY_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (fill_req && (src == BASE_ROUND)),
      .cnt   (rr_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lock_q <= '0;
      else if (lock_we) lock_q <= lock_wdata;
   end

   assign min_way   = lock_q[WAY_W-1:0];
   assign load_mode = lock_q[LOAD_BIT];

   always_comb begin
      base_way = (src == BASE_ROUND) ? rr_cnt : rnd_way;
      if (load_mode) pick = min_way;
      else           pick = base_way | min_way;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         way  <= '0;
         line <= '0;
      end else begin
         vld <= fill_req;
         if (fill_req) begin
            way  <= pick;
            line <= {fill_set, pick};
         end
      end
   end
endmodule

// File: rtl/victim_way_select.sv
module victim_way_select #(
   parameter int          NCH        = 2,
   parameter int          WAYS       = 4,
   parameter int          SET_W      = 5,
   parameter int          LOCK_W     = 32,
   parameter int          LOAD_BIT   = 31,
   parameter bit          HAS_RANDOM = 1'b1,
   parameter logic [15:0] LFSR_TAPS  = 16'hB400,
   parameter logic [15:0] LFSR_SEED  = 16'hACE1,
   localparam int WAY_W  = $clog2(WAYS),
   localparam int LINE_W = SET_W + WAY_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rr_mode,
   input  logic [NCH-1:0]        fill_req,
   input  logic [NCH*SET_W-1:0]  fill_set,
   input  logic [NCH-1:0]        lock_we,
   input  logic [LOCK_W-1:0]     lock_wdata,
   output logic [NCH*LOCK_W-1:0] lock_rdata,
   output logic [NCH-1:0]        vict_valid,
   output logic [NCH*WAY_W-1:0]  vict_way,
   output logic [NCH*LINE_W-1:0] vict_line
);
   initial begin
      if (WAYS < 2 || (1 << WAY_W) != WAYS) $error("victim_way_select: WAYS must be a power of two >= 2");
      if (WAY_W > 16)                       $error("victim_way_select: way field wider than LFSR");
      if (LOAD_BIT >= LOCK_W || LOAD_BIT < WAY_W) $error("victim_way_select: bad load bit position");
      if (NCH < 1 || SET_W < 1)             $error("victim_way_select: bad channel or set width");
   end

   logic [WAY_W-1:0] rnd_way;

   generate
      if (HAS_RANDOM) begin : g_rnd
         logic [15:0] lfsr_q;
         vsel_lfsr #(.W(16), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .state (lfsr_q)
         );
         assign rnd_way = lfsr_q[WAY_W-1:0];
      end else begin : g_no_rnd
         assign rnd_way = '0;
      end
   endgenerate

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         vsel_lane #(
            .WAY_W(WAY_W), .SET_W(SET_W), .LOCK_W(LOCK_W), .LOAD_BIT(LOAD_BIT)
         ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .rr_mode    (rr_mode),
            .rnd_way    (rnd_way),
            .fill_req   (fill_req[c]),
            .fill_set   (fill_set[c*SET_W +: SET_W]),
            .lock_we    (lock_we[c]),
            .lock_wdata (lock_wdata),
            .lock_q     (lock_rdata[c*LOCK_W +: LOCK_W]),
            .vld        (vict_valid[c]),
            .way        (vict_way[c*WAY_W +: WAY_W]),
            .line       (vict_line[c*LINE_W +: LINE_W])
         );
      end
   endgenerate
endmodule

// File: rtl/victim_way_select_chk.sv
module victim_way_select_chk #(
   parameter int NCH      = 2,
   parameter int SET_W    = 5,
   parameter int LOCK_W   = 32,
   parameter int LOAD_BIT = 31,
   parameter int WAY_W    = 2,
   parameter int LINE_W   = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rr_mode,
   input logic [NCH-1:0]        fill_req,
   input logic [NCH*SET_W-1:0]  fill_set,
   input logic [NCH-1:0]        lock_we,
   input logic [LOCK_W-1:0]     lock_wdata,
   input logic [NCH*LOCK_W-1:0] lock_rdata,
   input logic [NCH-1:0]        vict_valid,
   input logic [NCH*WAY_W-1:0]  vict_way,
   input logic [NCH*LINE_W-1:0] vict_line
);
   for (genvar c = 0; c < NCH; c++) begin : g_c
      AST_VALID_FOLLOWS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
         vict_valid[c] == $past(fill_req[c])) else $error("valid timing"); // R8

      AST_LOAD_FORCES_WAY: assert property (@(posedge clk) disable iff (!rst_n)
         (fill_req[c] && lock_rdata[c*LOCK_W + LOAD_BIT])
         |=> vict_way[c*WAY_W +: WAY_W] == $past(lock_rdata[c*LOCK_W +: WAY_W])) else $error("load way"); // R6

      AST_MIN_WAY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (fill_req[c] && !lock_rdata[c*LOCK_W + LOAD_BIT])
         |=> (vict_way[c*WAY_W +: WAY_W] & $past(lock_rdata[c*LOCK_W +: WAY_W]))
             == $past(lock_rdata[c*LOCK_W +: WAY_W])) else $error("min way"); // R5

      AST_LINE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
         fill_req[c] |=> vict_line[c*LINE_W +: LINE_W]
             == {$past(fill_set[c*SET_W +: SET_W]), vict_way[c*WAY_W +: WAY_W]}) else $error("line"); // R7

      AST_LOCK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
         lock_we[c] |=> lock_rdata[c*LOCK_W +: LOCK_W] == $past(lock_wdata)) else $error("readback"); // R9

      AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !lock_we[c] |=> $stable(lock_rdata[c*LOCK_W +: LOCK_W])) else $error("lock hold"); // R10
   end
endmodule

bind victim_way_select victim_way_select_chk #(
   .NCH(NCH), .SET_W(SET_W), .LOCK_W(LOCK_W), .LOAD_BIT(LOAD_BIT),
   .WAY_W(WAY_W), .LINE_W(LINE_W)
) u_chk (.*);

// File: tb/sim_victim_way_select.sv
module sim_victim_way_select;
   localparam int NCH = 2, SET_W = 5, LOCK_W = 32, WAY_W = 2, LINE_W = 7;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  rr_mode = 1'b1;
   logic [NCH-1:0]        fill_req = '0;
   logic [NCH*SET_W-1:0]  fill_set = '0;
   logic [NCH-1:0]        lock_we = '0;
   logic [LOCK_W-1:0]     lock_wdata = '0;
   logic [NCH*LOCK_W-1:0] lock_rdata;
   logic [NCH-1:0]        vict_valid;
   logic [NCH*WAY_W-1:0]  vict_way;
   logic [NCH*LINE_W-1:0] vict_line;

   int n_chk = 0;
   int n_fail = 0;
   int rr_cnt [NCH];

   always #5 clk = ~clk;

   victim_way_select u0 (.*);

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [WAY_W-1:0] way_of(input int c);
      return vict_way[c*WAY_W +: WAY_W];
   endfunction

   task automatic write_lock(input int c, input logic [LOCK_W-1:0] v);
      @(negedge clk);
      lock_we[c] = 1'b1; lock_wdata = v;
      @(negedge clk);
      lock_we = '0;
   endtask

   // one fill on a channel; returns the way seen one cycle later
   task automatic fill(input int c, input logic [SET_W-1:0] s, output logic [WAY_W-1:0] w);
      @(negedge clk);
      fill_req[c] = 1'b1;
      fill_set[c*SET_W +: SET_W] = s;
      @(negedge clk);
      fill_req = '0;
      w = way_of(c);
      check(vict_valid[c] === 1'b1, "R8 valid after fill", vict_valid[c], 1);
      check(vict_line[c*LINE_W +: LINE_W] === {s, w}, "R7 line index",
            vict_line[c*LINE_W +: LINE_W], {s, w});
      if (rr_mode) rr_cnt[c] = (rr_cnt[c] + 1) % 4;
   endtask

   task automatic t_reset;
      for (int c = 0; c < NCH; c++) begin
         check(vict_valid[c] === 1'b0, "R1 valid low", vict_valid[c], 0);
         check(lock_rdata[c*LOCK_W +: LOCK_W] === '0, "R1 lock zero", lock_rdata[c*LOCK_W +: LOCK_W], 0);
      end
   endtask

   task automatic t_round_robin;
      logic [WAY_W-1:0] w;
      rr_mode = 1'b1;
      for (int i = 0; i < 6; i++) begin
         int e;
         e = rr_cnt[0];
         fill(0, 5'(i + 3), w);
         check(w == WAY_W'(e), "R2 round-robin order", w, e);
         @(negedge clk);
         check(vict_valid[0] === 1'b0, "R8 valid drops", vict_valid[0], 0);
      end
   endtask

   task automatic t_no_advance;
      logic [WAY_W-1:0] w;
      int e;
      repeat (7) @(negedge clk);
      rr_mode = 1'b0;
      for (int i = 0; i < 3; i++) fill(0, 5'd1, w);
      rr_mode = 1'b1;
      e = rr_cnt[0];
      fill(0, 5'd2, w);
      check(w == WAY_W'(e), "R3 counter held", w, e);
   endtask

   task automatic t_random;
      logic [WAY_W-1:0] w;
      bit [3:0] seen = '0;
      bit [3:0] seen2 = '0;
      rr_mode = 1'b0;
      for (int i = 0; i < 64; i++) begin
         fill(0, 5'(i), w);
         seen[w] = 1'b1;
      end
      check(seen == 4'hF, "R4 all ways from LFSR", seen, 4'hF);
      write_lock(0, 32'h0000_0002);
      for (int i = 0; i < 32; i++) begin
         fill(0, 5'(i), w);
         seen2[w] = 1'b1;
      end
      check(seen2 == 4'hC, "R5 min way 2 random", seen2, 4'hC);
   endtask

   task automatic t_min_way_rr;
      logic [WAY_W-1:0] w;
      int e;
      rr_mode = 1'b1;
      write_lock(0, 32'h0000_0001);
      for (int i = 0; i < 4; i++) begin
         e = rr_cnt[0] | 1;
         fill(0, 5'd9, w);
         check(w == WAY_W'(e), "R5 OR with min way", w, e);
      end
   endtask

   task automatic t_load;
      logic [WAY_W-1:0] w;
      int e;
      write_lock(0, 32'h8000_0002);
      for (int i = 0; i < 3; i++) begin
         fill(0, 5'd30, w);
         check(w == 2'd2, "R6 load way rr", w, 2);
      end
      rr_mode = 1'b0;
      for (int i = 0; i < 5; i++) begin
         fill(0, 5'd31, w);
         check(w == 2'd2, "R6 load way random", w, 2);
      end
      rr_mode = 1'b1;
      write_lock(0, 32'h0000_0000);
      e = rr_cnt[0];
      fill(0, 5'd0, w);
      check(w == WAY_W'(e), "R2 counter stepped in load mode", w, e);
   endtask

   task automatic t_readback;
      write_lock(1, 32'h5A3C_96F0);
      check(lock_rdata[LOCK_W +: LOCK_W] === 32'h5A3C_96F0, "R9 all bits readback",
            lock_rdata[LOCK_W +: LOCK_W], 32'h5A3C_96F0);
      check(lock_rdata[0 +: LOCK_W] === 32'h0, "R10 other lock untouched", lock_rdata[0 +: LOCK_W], 0);
      write_lock(1, 32'h0000_0000);
   endtask

   task automatic t_same_cycle;
      // lock written with a fill: fill must use the old value
      rr_mode = 1'b1;
      @(negedge clk);
      fill_req[1] = 1'b1; fill_set[SET_W +: SET_W] = 5'd7;
      lock_we[1] = 1'b1; lock_wdata = 32'h8000_0003;
      @(negedge clk);
      fill_req = '0; lock_we = '0;
      check(way_of(1) == WAY_W'(rr_cnt[1]), "R8 fill uses old lock", way_of(1), rr_cnt[1]);
      rr_cnt[1] = (rr_cnt[1] + 1) % 4;
      write_lock(1, 32'h0000_0000);
   endtask

   task automatic t_independent;
      int e0, e1;
      rr_mode = 1'b1;
      write_lock(1, 32'h0000_0002);
      e0 = rr_cnt[0];
      e1 = rr_cnt[1] | 2;
      @(negedge clk);
      fill_req = 2'b11;
      fill_set = {5'd17, 5'd4};
      @(negedge clk);
      fill_req = '0;
      check(way_of(0) == WAY_W'(e0), "R10 ch0 own counter", way_of(0), e0);
      check(way_of(1) == WAY_W'(e1), "R10 ch1 own lock", way_of(1), e1);
      check(vict_line[LINE_W +: LINE_W] == {5'd17, WAY_W'(e1)}, "R7 ch1 line",
            vict_line[LINE_W +: LINE_W], {5'd17, WAY_W'(e1)});
      rr_cnt[0] = (rr_cnt[0] + 1) % 4;
      rr_cnt[1] = (rr_cnt[1] + 1) % 4;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) rr_cnt[c] = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_round_robin();
      t_no_advance();
      t_random();
      t_min_way_rr();
      t_load();
      t_readback();
      t_same_cycle();
      t_independent();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule